// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital feedback divider of an integer-N frequency synthesizer loop. It divides a fast input clock by a programmable ratio N = 64·B + A and emits one single-cycle pulse per N input cycles toward the phase comparator. Inside, a dual-modulus prescaler divides by 64 or 65. The prescaler is built from a synchronous divide-by-4/5 core followed by a 16-step extension counter. The core stretches to five cycles only once per prescaler cycle, and only while the modulus control asks for 65.

A swallow counter holds A and a main counter holds B. Both reload at the start of every output period, when the modulus control selects 65. After A prescaler cycles the swallow counter reaches zero and the modulus drops to 64. After B prescaler cycles the block produces the output pulse and both counters reload from the programmed values.

A and B may change at any time. They are only sampled at an output-period boundary, so a period in progress always finishes with the ratio it started with. A status output flags a programmed pair that breaks the B > A rule.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While rst_n is low, div_out and mod_sel are both 0.
- R2: For any programmed pair with swallow_i < main_i, consecutive div_out pulses are exactly 64·main_i + swallow_i input clock cycles apart. This includes the extremes 4096 (swallow_i = 0, main_i = 64) and 32767 (swallow_i = 63, main_i = 511).
- R3: div_out is high for exactly one clock cycle per output period.
- R4: Within each output period, mod_sel (1 = divide by 65, 0 = divide by 64) is high for the first swallow_i prescaler cycles, which is 65·swallow_i input cycles. It is low for the rest of the period, and low for the whole period when swallow_i is 0.
- R5: mod_sel can only rise in the cycle where div_out is high, which is the start of an output period.
- R6: A change of swallow_i or main_i in the middle of an output period does not alter that period. The new ratio applies from the next period on.
- R7: cfg_bad is 1 exactly when main_i ≤ swallow_i, following the inputs combinationally. It is 0 when main_i > swallow_i.
- R8: The 4/5 core runs a fifth state only while mod_sel is 1, so each prescaler cycle lasts 65 input cycles with mod_sel high and 64 with it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| swallow_i | input | 6 | Programmed swallow count A (0 to 63) |
| main_i | input | 9 | Programmed main count B |
| div_out | output | 1 | One-cycle pulse every N input cycles |
| mod_sel | output | 1 | Prescaler modulus control, 1 selects 65 |
| cfg_bad | output | 1 | Programmed pair violates B > A |

## Verification
The assertions need nothing from the inputs apart from a reset at start-up. They hold even for illegal pairs, because the counters reload whenever the main count runs out and the swallow count never wraps below zero. The stimulus keeps every pair it lets run within the legal space: main_i above swallow_i and main_i at least 64. Illegal pairs are only driven briefly between two clock edges, long enough to probe cfg_bad, and no edge samples them. Each new pair is applied just after an output pulse, so the period in progress shows that mid-period changes are deferred to the next boundary.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int A_W = 6,
  parameter int B_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  output logic           div_out,
  output logic           mod_sel,
  output logic           cfg_bad
);
  localparam int EXT_W = A_W - 2;

  logic             armed;
  logic [2:0]       core_q;
  logic [EXT_W-1:0] ext_q;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic             ext_last, core_end, pre_tick, wrap;

  assign mod_sel  = (a_q != '0);
  assign ext_last = &ext_q;
  assign core_end = (core_q == ((mod_sel && ext_last) ? 3'd4 : 3'd3));
  assign pre_tick = armed && core_end && ext_last;
  assign wrap     = pre_tick && (b_q <= 1);
  assign cfg_bad  = (main_i <= B_W'(swallow_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      core_q  <= '0;
      ext_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      div_out <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
      a_q   <= swallow_i;
      b_q   <= main_i;
    end else begin
      core_q  <= core_end ? 3'd0 : core_q + 3'd1;
      if (core_end) ext_q <= ext_q + 1'b1;
      div_out <= wrap;
      if (wrap) begin
        a_q <= swallow_i;
        b_q <= main_i;
      end else if (pre_tick) begin
        b_q <= b_q - 1'b1;
        if (a_q != '0) a_q <= a_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_divider_chk.sv
module pulse_swallow_divider_chk #(
  parameter int B_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           armed,
  input logic           div_out,
  input logic           mod_sel,
  input logic [2:0]     core_q,
  input logic [B_W-1:0] b_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!div_out && !mod_sel));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  assert_mod_rise_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> (div_out || !$past(armed)));

  assert_reload_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q > $past(b_q)) |-> (div_out || !$past(armed)));

  assert_fifth_state_only_r8_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_q == 3'd4) |-> mod_sel);

  assert_core_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_q <= 3'd4);
endmodule

bind pulse_swallow_divider pulse_swallow_divider_chk #(.B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .div_out(div_out),
  .mod_sel(mod_sel), .core_q(core_q), .b_q(b_q)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] swallow_i = '0;
  logic [8:0] main_i = 9'd64;
  logic       div_out, mod_sel, cfg_bad;
  int         checks = 0;
  int         errors = 0;
  int         cur_a, cur_b;

  always #10 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rst_n(rst_n), .swallow_i(swallow_i), .main_i(main_i),
    .div_out(div_out), .mod_sel(mod_sel), .cfg_bad(cfg_bad)
  );

  function automatic int exp_period(int a, int b);
    return 64 * b + a;
  endfunction

  function automatic int exp_mod(int a);
    return 65 * a;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n, output int m);
    n = 0; m = 0;
    do begin
      n++;
      if (mod_sel) m++;
      @(negedge clk);
    end while (!div_out);
  endtask

  task automatic probe_bad(int a, int b, int exp);
    swallow_i = 6'(a); main_i = 9'(b);
    #1 chk("R7 cfg_bad", int'(cfg_bad), exp);
  endtask

  task automatic next_cfg(int a, int b, string tag);
    int n, m;
    probe_bad(a, a, 1);
    swallow_i = 6'(a); main_i = 9'(b);
    #1 chk("R7 cfg_bad legal", int'(cfg_bad), 0);
    measure(n, m);
    chk("R6 old ratio kept", n, exp_period(cur_a, cur_b));
    cur_a = a; cur_b = b;
    measure(n, m);
    chk({"R2 period ", tag}, n, exp_period(a, b));
    chk({"R4 mod_sel cycles ", tag}, m, exp_mod(a));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, m, seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk("R1 div_out in reset", int'(div_out), 0);
    chk("R1 mod_sel in reset", int'(mod_sel), 0);
    probe_bad(5, 5, 1);
    probe_bad(10, 3, 1);
    probe_bad(0, 0, 1);
    probe_bad(5, 6, 0);
    swallow_i = 6'd0; main_i = 9'd64;
    cur_a = 0; cur_b = 64;
    @(negedge clk) rst_n = 1'b1;
    while (!div_out) @(negedge clk);
    measure(n, m);
    chk("R8 R2 min ratio 4096", n, 4096);
    chk("R4 mod_sel idle when A=0", m, 0);
    next_cfg(63, 64, "A=63 B=64");
    for (int i = 0; i < 5; i++) begin
      int a, b;
      a = int'($urandom % 64);
      b = a + 1 + int'($urandom % 21);
      if (b < 64) b = 64;
      next_cfg(a, b, "random");
    end
    next_cfg(1, 64, "A=1");
    next_cfg(63, 511, "R8 max ratio");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule